// File: doc/BRIEF.md
# Stopwatch Run Control

This block decides whether a tenths-of-a-second stopwatch is counting. It runs on a fast clock and receives a one-cycle `tick` pulse that marks the start of each slow counting period. Two push-button levels come in, already synchronised to the fast clock: one starts or stops the watch, the other clears it. A press may land on any fast cycle of a slow period. The block remembers it and acts on it at the next tick.

Both outputs are registers that change only on the clock edge at the end of a tick cycle. `run_o` tells the display datapath whether to advance. `clr_o` tells it to zero its digits. `clr_o` stays high for exactly one slow period, the one that begins at the tick that consumed the clear request.

The clear button always beats the start/stop button. A start/stop press is counted on the rising edge of its level. Holding the button down therefore toggles the watch only once, however long it is held.

Top module: `stopwatch_run_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first tick, `run_o` and `clr_o` are both 0.
- R2: `run_o` and `clr_o` change only on the clock edge that ends a cycle with `tick` high. On every other edge they hold their values.
- R3: A period runs from a tick cycle up to, but not including, the next tick cycle. If `btn_clr` is high on any cycle of the period, then at the next tick edge `run_o` becomes 0 and `clr_o` becomes 1.
- R4: At a tick edge with no clear request pending, `clr_o` becomes 0. A clear pulse therefore lasts exactly one period.
- R5: If a 0-to-1 transition of `btn_go` falls inside a period and no clear request is pending, then at the next tick edge `run_o` is inverted.
- R6: Holding `btn_go` high with no new 0-to-1 transition leaves `run_o` unchanged, even across several periods.
- R7: Several 0-to-1 transitions of `btn_go` inside one period cause a single inversion of `run_o`.
- R8: A period with no clear request and no `btn_go` rising edge leaves `run_o` unchanged at the next tick edge.
- R9: A button event on a tick cycle belongs to the period that this tick opens. It is acted on at the following tick, not at the current one, and it is not lost.
- R10: If both a clear request and a `btn_go` rising edge fall in the same period, the clear wins: `run_o` becomes 0 and `clr_o` becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse that opens each slow period |
| btn_go | input | 1 | Start/stop button level, synchronised to `clk` |
| btn_clr | input | 1 | Clear button level, synchronised to `clk` |
| run_o | output | 1 | Counting enable for the datapath |
| clr_o | output | 1 | Clear request, high for one slow period |

## Verification
The hardest cases to reach from the ports are the boundaries of a period. One is a press that lands exactly on the tick cycle. Another is a press on the last cycle before a tick. A third is a button held down from one period into the next. The stimulus describes each period as a per-cycle pattern of button levels, with cycle 0 being the tick cycle. This lets the bench place edges exactly on those boundaries, on both sides. A reference model follows the same patterns: it tracks the last `btn_go` level it saw, predicts the outputs after each tick, and queues the prediction for the monitor.

// File: rtl/stopwatch_run_ctrl.sv
module stopwatch_run_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic btn_go,
  input  logic btn_clr,
  output logic run_o,
  output logic clr_o
);

  logic go_q;
  logic go_pend;
  logic clr_pend;
  logic go_rise;

  assign go_rise = btn_go & ~go_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q     <= 1'b0;
      go_pend  <= 1'b0;
      clr_pend <= 1'b0;
      run_o    <= 1'b0;
      clr_o    <= 1'b0;
    end else begin
      go_q     <= btn_go;
      go_pend  <= tick ? go_rise : (go_pend | go_rise);
      clr_pend <= tick ? btn_clr : (clr_pend | btn_clr);
      if (tick) begin
        clr_o <= clr_pend;
        run_o <= ~clr_pend & (run_o ^ go_pend);
      end
    end
  end

endmodule

// File: rtl/stopwatch_run_ctrl_chk.sv
module stopwatch_run_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic btn_clr,
  input logic go_pend,
  input logic clr_pend,
  input logic run_o,
  input logic clr_o
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !run_o && !clr_o); // R1

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(run_o) && $stable(clr_o)); // R2

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && clr_pend |=> !run_o && clr_o); // R3 R10

  AST_CLR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr_pend |=> !clr_o); // R4

  AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr_pend && go_pend |=> run_o != $past(run_o)); // R5

  AST_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !clr_pend && !go_pend |=> run_o == $past(run_o)); // R8

  AST_CLR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    btn_clr |=> clr_pend); // R9

endmodule

bind stopwatch_run_ctrl stopwatch_run_ctrl_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .btn_clr  (btn_clr),
  .go_pend  (go_pend),
  .clr_pend (clr_pend),
  .run_o    (run_o),
  .clr_o    (clr_o)
);

// File: tb/stopwatch_run_ctrl_tb_top.sv
module stopwatch_run_ctrl_tb_top;

  localparam int PER = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic btn_go = 1'b0;
  logic btn_clr = 1'b0;
  logic run_o;
  logic clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    bit    run;
    bit    clr;
    string tag;
  } exp_t;

  exp_t q[$];
  bit m_run = 1'b0;
  bit m_go_prev = 1'b0;

  always #2.5 clk = ~clk;

  stopwatch_run_ctrl dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .btn_go  (btn_go),
    .btn_clr (btn_clr),
    .run_o   (run_o),
    .clr_o   (clr_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Drives one period (bit 0 of each mask is the tick cycle) and queues the
  // outputs expected after the tick that closes it.
  task automatic drive_period(input logic [PER-1:0] go_m,
                              input logic [PER-1:0] clr_m,
                              input string tag);
    bit edge_seen = 1'b0;
    bit clr_seen;
    exp_t e;
    for (int c = 0; c < PER; c++) begin
      @(negedge clk);
      tick    = (c == 0);
      btn_go  = go_m[c];
      btn_clr = clr_m[c];
      if (go_m[c] && !m_go_prev) edge_seen = 1'b1;
      m_go_prev = go_m[c];
    end
    clr_seen = |clr_m;
    if (clr_seen) m_run = 1'b0;
    else if (edge_seen) m_run = ~m_run;
    e.run = m_run;
    e.clr = clr_seen;
    e.tag = tag;
    q.push_back(e);
  endtask

  initial begin : monitor
    bit t;
    logic pr = 1'b0;
    logic pc = 1'b0;
    exp_t e;
    forever begin
      @(posedge clk);
      t = tick;
      @(negedge clk);
      if (rst_n) begin
        if (t) begin
          if (q.size() == 0) begin
            check(1'b0, "R2", "unexpected tick result", 0, 1);
          end else begin
            e = q.pop_front();
            check(run_o == e.run, e.tag, "run_o", run_o, e.run);
            check(clr_o == e.clr, e.tag, "clr_o", clr_o, e.clr);
          end
        end else begin
          check(run_o == pr && clr_o == pc, "R2", "hold between ticks",
                {run_o, clr_o}, {pr, pc});
        end
      end
      pr = run_o;
      pc = clr_o;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    exp_t e0;
    repeat (3) @(negedge clk);
    check(run_o == 1'b0, "R1", "run_o in reset", run_o, 0);
    check(clr_o == 1'b0, "R1", "clr_o in reset", clr_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(run_o == 1'b0 && clr_o == 1'b0, "R1", "outputs before first tick",
          {run_o, clr_o}, 0);
    e0.run = 1'b0; e0.clr = 1'b0; e0.tag = "R1";
    q.push_back(e0);
    drive_period(8'h00, 8'h00, "R8");
    drive_period(8'h08, 8'h00, "R5");
    drive_period(8'h00, 8'h00, "R8");
    drive_period(8'hFF, 8'h00, "R5");
    drive_period(8'hFF, 8'h00, "R6");
    drive_period(8'h54, 8'h00, "R7");
    drive_period(8'h00, 8'h80, "R3");
    drive_period(8'h00, 8'h00, "R4");
    drive_period(8'h02, 8'h00, "R5");
    drive_period(8'h10, 8'h20, "R10");
    drive_period(8'h00, 8'h00, "R4");
    drive_period(8'h01, 8'h00, "R9");
    drive_period(8'h00, 8'h01, "R9");
    drive_period(8'h00, 8'h00, "R4");
    @(negedge clk);
    tick = 1'b1; btn_go = 1'b0; btn_clr = 1'b0;
    @(negedge clk);
    tick = 1'b0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R2", "all tick results seen", q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule